// File: doc/BRIEF.md
# Per-CPU Level Interrupt Router

This block collects a wide set of level-sensitive peripheral request lines (64 or 128) and produces one interrupt output per CPU. Every CPU owns a private register bank of 32-bit enable words and read-only status words. Setting a bit in one bank's enable word steers the matching input to that CPU. Setting the same bit in several banks steers it to several CPUs.

A request line counts as pending for as long as it is high. There is no edge, polarity or priority logic. Software handles an interrupt by reading every status word of its own bank, because no vector or encoded result is produced. Each bank is reached through a 32-byte window on a simple single-cycle register bus. Read data returns one cycle after the read strobe.

Top module: `pcpu_irq_agg`

## Requirements
- R1: After reset every enable bit in every bank is zero, every `irq_out` bit is low and `rdata` is zero, whatever the request lines carry.
- R2: Bank b occupies byte addresses 32*b to 32*b+31, and `addr[1:0]` is ignored. With W = NUM_LINES/32 words, enable word k sits at byte offset 4*(W-1-k), so the highest-numbered word comes first. A write there stores all 32 bits, and a read returns them.
- R3: Status word k of a bank sits at byte offset 4*W + 4*(W-1-k). A read returns `irq_in[32k+31:32k]` AND that bank's enable word k, sampled in the cycle of the read.
- R4: Writes to status offsets change neither any enable word nor any later status value.
- R5: Each `irq_out[c]` is a register. It goes high in the cycle after some `irq_in` bit is high with its enable bit set in bank c, and low in the cycle after no such bit remains.
- R6: Banks are independent. A write to bank b changes no other bank's enables, status or output.
- R7: An input whose enable bit is clear in a bank shows as zero in that bank's status and never raises that bank's output.
- R8: A read returns zero at an unmapped offset (byte offset 8*W and above, or a bank number ≥ NUM_CPUS), and a write there has no effect.
- R9: `rdata` shows the addressed value in the cycle after `rd_en` is high, and is zero in every cycle that follows a cycle without a read.
- R10: Bit j of word k corresponds to input line 32k+j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_LINES | Level-sensitive request lines, high means pending |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` / `wdata` |
| addr | input | ADDR_W | Byte address, bank number above bit 4 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq_out | output | NUM_CPUS | One registered interrupt per CPU |

## Verification
The hardest case to reach is an input that is high but is enabled in one bank only, while the other bank's output and status must stay quiet. The bench enables disjoint bit sets in the two banks. It then drives patterns that hit the top word, the bottom word and bits that are not enabled, and reads both banks after each pattern. Writes aimed at status and unmapped offsets come between these reads, so any leak into an enable word shows up in a later readback or output.

// File: rtl/pcpu_irq_pkg.sv
package pcpu_irq_pkg;

    localparam int unsigned WORD_W   = 32;
    localparam int unsigned WIN_LSB  = 5;   // 32-byte window per bank
    localparam int unsigned WIN_SLOTS = 8;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        SLOT_NONE = 2'd0,
        SLOT_EN   = 2'd1,
        SLOT_ST   = 2'd2
    } slot_e;

    function automatic int unsigned bank_bits(int unsigned ncpu);
        return (ncpu > 1) ? $clog2(ncpu) : 1;
    endfunction

    function automatic int unsigned addr_width(int unsigned ncpu);
        return WIN_LSB + bank_bits(ncpu);
    endfunction

    function automatic int unsigned idx_bits(int unsigned nwords);
        return (nwords > 1) ? $clog2(nwords) : 1;
    endfunction

endpackage

// File: rtl/pcpu_irq_decode.sv
module pcpu_irq_decode
    import pcpu_irq_pkg::*;
#(
    parameter int unsigned NUM_CPUS = 2,
    parameter int unsigned NWORDS   = 2,
    parameter int unsigned ADDR_W   = addr_width(NUM_CPUS),
    localparam int unsigned IDX_W   = idx_bits(NWORDS)
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CPUS-1:0] bank_hit,
    output slot_e               kind,
    output logic [IDX_W-1:0]    word_idx
);
    int unsigned slot;
    int unsigned bank;
    logic [31:0] idx_full;

    always_comb begin
        slot     = int'(addr[WIN_LSB-1:2]);
        bank     = int'(addr[ADDR_W-1:WIN_LSB]);
        kind     = SLOT_NONE;
        idx_full = '0;
        if (slot < NWORDS) begin
            kind     = SLOT_EN;
            idx_full = 32'(NWORDS - 1 - slot);
        end else if (slot < 2 * NWORDS) begin
            kind     = SLOT_ST;
            idx_full = 32'(2 * NWORDS - 1 - slot);
        end
        word_idx = idx_full[IDX_W-1:0];
        for (int c = 0; c < NUM_CPUS; c++) begin
            bank_hit[c] = (bank == c) && (kind != SLOT_NONE);
        end
    end

endmodule

// File: rtl/pcpu_irq_bank.sv
module pcpu_irq_bank
    import pcpu_irq_pkg::*;
#(
    parameter int unsigned NWORDS = 2,
    localparam int unsigned IDX_W = idx_bits(NWORDS),
    localparam int unsigned LINES = NWORDS * WORD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             en_wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  word_t            wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output word_t            en_word,
    output word_t            st_word,
    output logic             cpu_irq
);
    typedef struct packed {
        logic [NWORDS-1:0][WORD_W-1:0] en;
        logic                          irq;
    } bank_state_t;

    bank_state_t s_d, s_q;
    logic [NWORDS-1:0][WORD_W-1:0] masked;

    assign masked = lines & s_q.en;

    always_comb begin
        s_d = s_q;
        if (en_wr) begin
            s_d.en[wr_idx] = wr_data;
        end
        s_d.irq = |masked;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign en_word = s_q.en[rd_idx];
    assign st_word = masked[rd_idx];
    assign cpu_irq = s_q.irq;

endmodule

// File: rtl/pcpu_irq_agg.sv
module pcpu_irq_agg
    import pcpu_irq_pkg::*;
#(
    parameter int unsigned NUM_CPUS  = 2,
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned ADDR_W    = addr_width(NUM_CPUS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 rd_en,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    output logic [NUM_CPUS-1:0]  irq_out
);
    localparam int unsigned NWORDS = NUM_LINES / WORD_W;
    localparam int unsigned IDX_W  = idx_bits(NWORDS);

    typedef struct packed {
        word_t rdata;
    } port_state_t;

    port_state_t p_d, p_q;

    logic [NUM_CPUS-1:0] bank_hit;
    slot_e               kind;
    logic [IDX_W-1:0]    word_idx;
    word_t               en_word [NUM_CPUS];
    word_t               st_word [NUM_CPUS];

    pcpu_irq_decode #(
        .NUM_CPUS (NUM_CPUS),
        .NWORDS   (NWORDS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .addr     (addr),
        .bank_hit (bank_hit),
        .kind     (kind),
        .word_idx (word_idx)
    );

    for (genvar g = 0; g < NUM_CPUS; g++) begin : g_bank
        pcpu_irq_bank #(
            .NWORDS (NWORDS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lines   (irq_in),
            .en_wr   (wr_en && bank_hit[g] && (kind == SLOT_EN)),
            .wr_idx  (word_idx),
            .wr_data (wdata),
            .rd_idx  (word_idx),
            .en_word (en_word[g]),
            .st_word (st_word[g]),
            .cpu_irq (irq_out[g])
        );
    end

    always_comb begin
        p_d.rdata = '0;
        if (rd_en) begin
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (bank_hit[c]) begin
                    p_d.rdata = (kind == SLOT_EN) ? en_word[c] : st_word[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q <= '0;
        end else begin
            p_q <= p_d;
        end
    end

    assign rdata = p_q.rdata;

endmodule

// File: rtl/pcpu_irq_agg_chk.sv
module pcpu_irq_agg_chk
    import pcpu_irq_pkg::*;
#(
    parameter int unsigned NUM_CPUS  = 2,
    parameter int unsigned NUM_LINES = 64,
    parameter int unsigned ADDR_W    = addr_width(NUM_CPUS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_in,
    input logic                 rd_en,
    input logic [ADDR_W-1:0]    addr,
    input logic [31:0]          rdata,
    input logic [NUM_CPUS-1:0]  irq_out
);
    localparam int unsigned NWORDS = NUM_LINES / WORD_W;

    int unsigned slot;
    int unsigned bank;
    logic        is_status;
    logic        is_unmapped;
    word_t       raw_word;

    always_comb begin
        slot        = int'(addr[WIN_LSB-1:2]);
        bank        = int'(addr[ADDR_W-1:WIN_LSB]);
        is_unmapped = (slot >= 2 * NWORDS) || (bank >= NUM_CPUS);
        is_status   = !is_unmapped && (slot >= NWORDS);
        raw_word    = '0;
        for (int k = 0; k < NWORDS; k++) begin
            if (is_status && (slot == 2 * NWORDS - 1 - k)) begin
                raw_word = irq_in[k*WORD_W +: WORD_W];
            end
        end
    end

    // R9: no read strobe, no read data
    a_r9_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));

    // R8: unmapped reads return zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_unmapped) |=> (rdata == '0));

    // R3: a status read never shows a line that was low
    a_r3_status_subset: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && is_status) |=> ((rdata & ~$past(raw_word)) == '0));

    // R5: all lines low keeps every output low next cycle
    a_r5_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_in == '0) |=> (irq_out == '0));

    // R7: an output high implies some line was high a cycle earlier
    a_r7_out_needs_line: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> $past(irq_in != '0));

endmodule

bind pcpu_irq_agg pcpu_irq_agg_chk #(
    .NUM_CPUS  (NUM_CPUS),
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .irq_out (irq_out)
);

// File: tb/pcpu_irq_agg_bench.sv
module pcpu_irq_agg_bench;
    localparam int NUM_CPUS  = 2;
    localparam int NUM_LINES = 64;
    localparam int ADDR_W    = 6;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_LINES-1:0] irq_in = '1;
    logic                 rd_en = 1'b0;
    logic                 wr_en = 1'b0;
    logic [ADDR_W-1:0]    addr = '0;
    logic [31:0]          wdata = '0;
    logic [31:0]          rdata;
    logic [NUM_CPUS-1:0]  irq_out;

    int checks = 0;
    int errors = 0;
    bit pend = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;

    pcpu_irq_agg #(
        .NUM_CPUS  (NUM_CPUS),
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W)
    ) u_pcpu_irq_agg (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_in  (irq_in),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq_out (irq_out)
    );

    // monitor: pops one expected item for every read strobe seen
    initial forever begin
        @(negedge clk);
        #1;
        if (pend) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (rdata !== it.exp) begin
                errors++;
                $display("FAIL %s: rdata=%08h expected=%08h", it.tag, rdata, it.exp);
            end
        end
        pend = rd_en;
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_in(input logic [NUM_LINES-1:0] v);
        @(negedge clk);
        irq_in = v;
    endtask

    task automatic chk_out(input logic [NUM_CPUS-1:0] e, input string tag);
        @(negedge clk);
        #2;
        checks++;
        if (irq_out !== e) begin
            errors++;
            $display("FAIL %s: irq_out=%b expected=%b", tag, irq_out, e);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all lines high, nothing enabled
        chk_out(2'b00, "R1 outputs after reset");
        checks++;
        if (rdata !== 32'h0) begin
            errors++;
            $display("FAIL R1 rdata after reset: %08h expected 00000000", rdata);
        end
        rd(6'h00, 32'h0, "R1 bank0 en1");
        rd(6'h04, 32'h0, "R1 bank0 en0");
        rd(6'h0C, 32'h0, "R1 R7 bank0 st0");
        rd(6'h28, 32'h0, "R1 bank1 st1");
        set_in('0);

        // R2: enable words, highest word first
        wr(6'h04, 32'h0000_00F0);
        wr(6'h00, 32'h8000_0001);
        rd(6'h04, 32'h0000_00F0, "R2 en0 readback");
        rd(6'h00, 32'h8000_0001, "R2 en1 readback");

        // R7: line 0 not enabled
        set_in(64'h1);
        chk_out(2'b00, "R7 disabled line");
        rd(6'h0C, 32'h0, "R7 status masked");

        // R3 R5 R6
        set_in(64'h30);
        chk_out(2'b01, "R5 R6 bank0 only");
        rd(6'h0C, 32'h0000_0030, "R3 st0 masked");

        // R10: upper word mapping
        set_in(64'h3_0000_0000);
        rd(6'h08, 32'h0000_0001, "R10 line 32 in st1 bit0");
        set_in(64'h8000_0000_0000_0000);
        rd(6'h08, 32'h8000_0000, "R10 line 63 in st1 bit31");
        chk_out(2'b01, "R10 line 63 raises bank0");

        // R4: status writes ignored
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h08, 32'hFFFF_FFFF);
        rd(6'h04, 32'h0000_00F0, "R4 en0 unchanged");
        rd(6'h00, 32'h8000_0001, "R4 en1 unchanged");
        set_in('0);
        rd(6'h0C, 32'h0, "R4 st0 still masked");

        // R6 R5: bank1 alone, output timing
        wr(6'h24, 32'h0000_0001);
        set_in(64'h1);
        #1;
        checks++;
        if (irq_out !== 2'b00) begin
            errors++;
            $display("FAIL R5 output before edge: %b expected 00", irq_out);
        end
        chk_out(2'b10, "R5 R6 bank1 raised one cycle later");
        rd(6'h2C, 32'h1, "R6 bank1 st0");
        rd(6'h0C, 32'h0, "R6 bank0 st0 unaffected");
        rd(6'h04, 32'h0000_00F0, "R6 bank0 en0 unaffected");

        // R8: unmapped offsets
        wr(6'h10, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h30, 32'hFFFF_FFFF);
        rd(6'h10, 32'h0, "R8 unmapped bank0");
        rd(6'h3C, 32'h0, "R8 unmapped bank1");
        rd(6'h24, 32'h1, "R8 bank1 en0 unchanged");
        rd(6'h00, 32'h8000_0001, "R8 bank0 en1 unchanged");

        // R9: idle cycle after reads
        @(negedge clk);
        #2;
        checks++;
        if (rdata !== 32'h0) begin
            errors++;
            $display("FAIL R9 rdata idle: %08h expected 00000000", rdata);
        end

        // R3: all lines high, both banks
        set_in('1);
        chk_out(2'b11, "R3 R5 both outputs");
        rd(6'h0C, 32'h0000_00F0, "R3 bank0 st0");
        rd(6'h08, 32'h8000_0001, "R3 bank0 st1");
        rd(6'h2C, 32'h0000_0001, "R3 bank1 st0");
        rd(6'h28, 32'h0, "R3 bank1 st1");

        // R5: lines drop
        set_in('0);
        chk_out(2'b00, "R5 outputs fall");

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R9 pending reads: %0d expected 0", sb.size());
        end
        finish_run();
    end

endmodule